// File: doc/BRIEF.md
# Dual-Stack Domain Execution Unit

This block is one typed execution domain of a stack-first processor core. It holds two separate LIFO operand stacks. The main stack is the full evaluation surface: every arithmetic, logical, shift and compare operation reads its operands from the top of this stack and pushes its result back onto it. The staging stack is a lighter surface for preparing and holding values. It supports only increment, decrement and simple bitwise operations on its top entries, plus pushes and pops through moves.

Two register banks sit beside the stacks. A read-only bank of four constants lets an instruction with no immediate field push a common literal. A writable bank of four pinned registers keeps long-lived values out of the stacks. Each ALU operation has a consuming form, which pops its operands, and a preserving form, which reads them in place and pushes the result above them.

Instructions arrive as an 8-bit word on a valid/ready handshake, and each accepted instruction completes in one cycle. The upper nibble selects the class and the lower nibble selects the sub-operation. An instruction that would pop from an empty stack or push onto a full one is discarded. It moves a two-state controller from `S_CLEAN` to `S_FAULT`, and the controller stays in `S_FAULT` until reset. The `S_CLEAN`→`S_FAULT` transition is the only transition besides reset, which returns the controller to `S_CLEAN`.

Top module: `dual_stack_domain`

## Requirements
- R1: A synchronous active-high reset empties both stacks (depth 0), clears all four pinned registers to 0, puts the controller in `S_CLEAN` (`fault` low) and leaves `in_ready` high.
- R2: Opcode 0x1k (k = bits 1:0) pushes constant k onto the main stack, with k=0→0x00000000, k=1→0x00000001, k=2→0xFFFFFFFF and k=3→0x80000000.
- R3: An instruction that would pop more entries than a stack holds, or push onto a stack holding 8 entries, changes no stack or pinned register. It raises `fault`, which stays high until reset.
- R4: Consuming ALU opcode 0x8s pops top b and next a, pushes (a op b), and lowers the main depth by one. It needs at least 2 entries.
- R5: Preserving ALU opcode 0x9s leaves a and b in place and pushes (a op b) above them, raising the main depth by one. It needs at least 2 entries and fewer than 8.
- R6: The ALU select s is 0 ADD, 1 SUB (a−b), 2 AND, 3 OR, 4 XOR, 5 SHL (a<<b[4:0]), 6 SHR logical, 7 EQ, 8 unsigned LT (a<b). Compares push 1 or 0.
- R7: Opcode 0x2p pushes pinned register p onto the main stack. Opcode 0x3p pops the main top into pinned register p (p = bits 1:0).
- R8: Opcode 0x40 pops the main top and pushes it onto the staging stack. Opcode 0x50 does the reverse. Each takes one cycle.
- R9: Staging opcode 0xAs works on the staging stack. For s = 0 (increment), 1 (decrement) and 2 (NOT), it replaces the top. For s = 3, 4 and 5 (AND, OR, XOR), it pops the top two entries and pushes their combination.
- R10: Opcode 0x60 pops and discards the main top. Opcode 0x70 pops and discards the staging top.
- R11: With `in_valid` low, and for the undefined opcodes (class 0, classes 0xB–0xF, ALU select above 8, staging select above 5), no state changes and `fault` is not raised.
- R12: `main_top` and `stage_top` show the top entry of each stack, or 0 when that stack is empty. `main_depth` and `stage_depth` show the entry counts, from 0 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word valid |
| in_ready | output | 1 | Unit can accept an instruction (always high) |
| in_op | input | 8 | Instruction word: class in bits 7:4, selector in bits 3:0 |
| main_top | output | 32 | Top entry of the main stack |
| main_depth | output | 4 | Main stack entry count |
| stage_top | output | 32 | Top entry of the staging stack |
| stage_depth | output | 4 | Staging stack entry count |
| fault | output | 1 | Sticky overflow/underflow flag |

## Verification
A corrupted depth counter shows up on the depth outputs, and in the top value, on the first falling edge after the instruction that caused it. A stale or misaddressed stack entry can stay hidden until a pop or a move brings it to the top. For that reason, every stimulus sequence unwinds the stacks through pops, moves and consuming operations. A wrong pinned register shows up only when it is loaded back, so every store is followed by a load. A missed or spurious fault shows on `fault` one cycle after the offending instruction, and the unchanged depths are compared in that same cycle.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

    typedef enum logic [3:0] {
        OPC_NOP   = 4'h0,
        OPC_PUSHK = 4'h1,
        OPC_LDPIN = 4'h2,
        OPC_STPIN = 4'h3,
        OPC_M2S   = 4'h4,
        OPC_S2M   = 4'h5,
        OPC_DROPM = 4'h6,
        OPC_DROPS = 4'h7,
        OPC_ALUC  = 4'h8,
        OPC_ALUP  = 4'h9,
        OPC_STG   = 4'hA
    } opclass_e;

    typedef enum logic [3:0] {
        ALU_ADD = 4'h0,
        ALU_SUB = 4'h1,
        ALU_AND = 4'h2,
        ALU_OR  = 4'h3,
        ALU_XOR = 4'h4,
        ALU_SHL = 4'h5,
        ALU_SHR = 4'h6,
        ALU_EQ  = 4'h7,
        ALU_LT  = 4'h8
    } alusel_e;

    typedef enum logic [3:0] {
        STG_INC = 4'h0,
        STG_DEC = 4'h1,
        STG_NOT = 4'h2,
        STG_AND = 4'h3,
        STG_OR  = 4'h4,
        STG_XOR = 4'h5
    } stgsel_e;

    typedef enum logic {
        S_CLEAN = 1'b0,
        S_FAULT = 1'b1
    } ctl_state_e;

    function automatic logic [31:0] const_word(input logic [1:0] idx);
        case (idx)
            2'd0:    return 32'h0000_0000;
            2'd1:    return 32'h0000_0001;
            2'd2:    return 32'hFFFF_FFFF;
            default: return 32'h8000_0000;
        endcase
    endfunction

endpackage

// File: rtl/lifo_stack.sv
module lifo_stack #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    pop_n,
    input  logic          push_en,
    input  logic [W-1:0]  push_data,
    output logic [W-1:0]  top0,
    output logic [W-1:0]  top1,
    output logic [CW-1:0] depth
);

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] base;
    logic [CW-1:0] d_m1;
    logic [CW-1:0] d_m2;

    assign base = depth - CW'(pop_n);
    assign d_m1 = depth - CW'(1);
    assign d_m2 = depth - CW'(2);

    always_ff @(posedge clk) begin
        if (rst) begin
            depth <= '0;
        end else begin
            depth <= base + CW'(push_en);
            if (push_en) begin
                mem[base[AW-1:0]] <= push_data;
            end
        end
    end

    always_comb begin
        top0 = (depth >= CW'(1)) ? mem[d_m1[AW-1:0]] : '0;
        top1 = (depth >= CW'(2)) ? mem[d_m2[AW-1:0]] : '0;
    end

endmodule

// File: rtl/dsd_alu.sv
module dsd_alu
    import dsd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   sel,
    output logic [W-1:0] res,
    output logic         known
);

    localparam int SH = $clog2(W);

    always_comb begin
        known = 1'b1;
        res   = '0;
        case (alusel_e'(sel))
            ALU_ADD: res = a + b;
            ALU_SUB: res = a - b;
            ALU_AND: res = a & b;
            ALU_OR:  res = a | b;
            ALU_XOR: res = a ^ b;
            ALU_SHL: res = a << b[SH-1:0];
            ALU_SHR: res = a >> b[SH-1:0];
            ALU_EQ:  res = W'(a == b);
            ALU_LT:  res = W'(a < b);
            default: known = 1'b0;
        endcase
    end

endmodule

// File: rtl/dsd_stage_alu.sv
module dsd_stage_alu
    import dsd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] top0,
    input  logic [W-1:0] top1,
    input  logic [3:0]   sel,
    output logic [W-1:0] res,
    output logic         binary,
    output logic         known
);

    always_comb begin
        known  = 1'b1;
        binary = 1'b0;
        res    = '0;
        case (stgsel_e'(sel))
            STG_INC: res = top0 + W'(1);
            STG_DEC: res = top0 - W'(1);
            STG_NOT: res = ~top0;
            STG_AND: begin res = top1 & top0; binary = 1'b1; end
            STG_OR:  begin res = top1 | top0; binary = 1'b1; end
            STG_XOR: begin res = top1 ^ top0; binary = 1'b1; end
            default: known = 1'b0;
        endcase
    end

endmodule

// File: rtl/dual_stack_domain.sv
module dual_stack_domain
    import dsd_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    parameter int NPIN  = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = $clog2(NPIN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [7:0]    in_op,
    output logic [W-1:0]  main_top,
    output logic [CW-1:0] main_depth,
    output logic [W-1:0]  stage_top,
    output logic [CW-1:0] stage_depth,
    output logic          fault
);

    ctl_state_e state, state_nx;

    logic [3:0]    opc_raw;
    logic [3:0]    sub;
    logic [W-1:0]  m_t0, m_t1, s_t0, s_t1;
    logic [W-1:0]  alu_res, stg_res;
    logic          alu_known, stg_known, stg_bin;
    logic [W-1:0]  pins [NPIN];
    logic [PW-1:0] pidx;

    logic [1:0]    m_pop, s_pop;
    logic          m_push, s_push;
    logic [W-1:0]  m_wd, s_wd;
    logic          pin_we, act, legal, fire, bad;

    assign opc_raw  = in_op[7:4];
    assign sub      = in_op[3:0];
    assign pidx     = sub[PW-1:0];
    assign in_ready = 1'b1;

    dsd_alu #(.W(W)) u_alu (
        .a     (m_t1),
        .b     (m_t0),
        .sel   (sub),
        .res   (alu_res),
        .known (alu_known)
    );

    dsd_stage_alu #(.W(W)) u_salu (
        .top0   (s_t0),
        .top1   (s_t1),
        .sel    (sub),
        .res    (stg_res),
        .binary (stg_bin),
        .known  (stg_known)
    );

    // Decode: what the instruction would do and whether the stack bounds allow it
    always_comb begin
        m_pop  = 2'd0;
        s_pop  = 2'd0;
        m_push = 1'b0;
        s_push = 1'b0;
        m_wd   = '0;
        s_wd   = '0;
        pin_we = 1'b0;
        act    = 1'b1;
        legal  = 1'b1;
        case (opc_raw)
            OPC_PUSHK: begin
                m_push = 1'b1;
                m_wd   = W'(const_word(sub[1:0]));
                legal  = main_depth < CW'(DEPTH);
            end
            OPC_LDPIN: begin
                m_push = 1'b1;
                m_wd   = pins[pidx];
                legal  = main_depth < CW'(DEPTH);
            end
            OPC_STPIN: begin
                m_pop  = 2'd1;
                pin_we = 1'b1;
                legal  = main_depth >= CW'(1);
            end
            OPC_M2S: begin
                m_pop  = 2'd1;
                s_push = 1'b1;
                s_wd   = m_t0;
                legal  = (main_depth >= CW'(1)) && (stage_depth < CW'(DEPTH));
            end
            OPC_S2M: begin
                s_pop  = 2'd1;
                m_push = 1'b1;
                m_wd   = s_t0;
                legal  = (stage_depth >= CW'(1)) && (main_depth < CW'(DEPTH));
            end
            OPC_DROPM: begin
                m_pop  = 2'd1;
                legal  = main_depth >= CW'(1);
            end
            OPC_DROPS: begin
                s_pop  = 2'd1;
                legal  = stage_depth >= CW'(1);
            end
            OPC_ALUC: begin
                act    = alu_known;
                m_pop  = 2'd2;
                m_push = 1'b1;
                m_wd   = alu_res;
                legal  = main_depth >= CW'(2);
            end
            OPC_ALUP: begin
                act    = alu_known;
                m_push = 1'b1;
                m_wd   = alu_res;
                legal  = (main_depth >= CW'(2)) && (main_depth < CW'(DEPTH));
            end
            OPC_STG: begin
                act    = stg_known;
                s_pop  = stg_bin ? 2'd2 : 2'd1;
                s_push = 1'b1;
                s_wd   = stg_res;
                legal  = stg_bin ? (stage_depth >= CW'(2)) : (stage_depth >= CW'(1));
            end
            default: act = 1'b0;
        endcase
    end

    assign fire = in_valid && act && legal;
    assign bad  = in_valid && act && !legal;

    lifo_stack #(.W(W), .DEPTH(DEPTH)) u_main (
        .clk       (clk),
        .rst       (rst),
        .pop_n     (fire ? m_pop : 2'd0),
        .push_en   (fire && m_push),
        .push_data (m_wd),
        .top0      (m_t0),
        .top1      (m_t1),
        .depth     (main_depth)
    );

    lifo_stack #(.W(W), .DEPTH(DEPTH)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .pop_n     (fire ? s_pop : 2'd0),
        .push_en   (fire && s_push),
        .push_data (s_wd),
        .top0      (s_t0),
        .top1      (s_t1),
        .depth     (stage_depth)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPIN; i++) begin
                pins[i] <= '0;
            end
        end else if (fire && pin_we) begin
            pins[pidx] <= m_t0;
        end
    end

    // Controller state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_CLEAN;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_CLEAN: if (bad) state_nx = S_FAULT;
            S_FAULT: state_nx = S_FAULT;
        endcase
    end

    // Controller outputs
    always_comb begin
        unique case (state)
            S_CLEAN: fault = 1'b0;
            S_FAULT: fault = 1'b1;
        endcase
    end

    assign main_top  = m_t0;
    assign stage_top = s_t0;

endmodule

// File: rtl/dsd_checker.sv
module dsd_checker #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic [7:0]    in_op,
    input logic [W-1:0]  main_top,
    input logic [CW-1:0] main_depth,
    input logic [W-1:0]  stage_top,
    input logic [CW-1:0] stage_depth,
    input logic          fault
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (main_depth == '0) && (stage_depth == '0) && !fault && in_ready);

    assert_depth_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (main_depth <= CW'(DEPTH)) && (stage_depth <= CW'(DEPTH)));

    assert_fault_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[7:4] == 4'h1 && main_depth == CW'(DEPTH))
        |=> fault && $stable(main_depth) && $stable(main_top));

    assert_consume_depth_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 8'h80 && main_depth >= CW'(2))
        |=> main_depth == $past(main_depth) - CW'(1));

    assert_preserve_depth_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 8'h90 && main_depth >= CW'(2) && main_depth < CW'(DEPTH))
        |=> main_depth == $past(main_depth) + CW'(1));

    assert_move_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 8'h40 && main_depth >= CW'(1) && stage_depth < CW'(DEPTH))
        |=> (stage_top == $past(main_top)) && (stage_depth == $past(stage_depth) + CW'(1)));

    assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(main_depth) && $stable(stage_depth)
                      && $stable(main_top) && $stable(stage_top));

    assert_empty_top_R12: assert property (@(posedge clk) disable iff (rst)
        (main_depth == '0) |-> (main_top == '0));

endmodule

bind dual_stack_domain dsd_checker #(.W(W), .DEPTH(DEPTH)) u_dsd_checker (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_op       (in_op),
    .main_top    (main_top),
    .main_depth  (main_depth),
    .stage_top   (stage_top),
    .stage_depth (stage_depth),
    .fault       (fault)
);

// File: tb/test_dual_stack_domain.sv
module test_dual_stack_domain;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [7:0]  in_op;
    logic [31:0] main_top, stage_top;
    logic [3:0]  main_depth, stage_depth;
    logic        fault;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] mq[$];
    logic [31:0] sq[$];
    logic [31:0] pin_m [4];
    bit          err_m;

    always #5 clk = ~clk;

    dual_stack_domain i_dual_stack_domain (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_op       (in_op),
        .main_top    (main_top),
        .main_depth  (main_depth),
        .stage_top   (stage_top),
        .stage_depth (stage_depth),
        .fault       (fault)
    );

    function automatic logic [31:0] kval(input int k);
        case (k)
            0: return 32'd0;
            1: return 32'd1;
            2: return 32'hFFFF_FFFF;
            default: return 32'h8000_0000;
        endcase
    endfunction

    function automatic logic [31:0] alu_f(input int s, input logic [31:0] a, input logic [31:0] b);
        case (s)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return a << b[4:0];
            6: return a >> b[4:0];
            7: return (a == b) ? 32'd1 : 32'd0;
            default: return (a < b) ? 32'd1 : 32'd0;
        endcase
    endfunction

    task automatic model_step(input logic [7:0] op);
        int c = op[7:4];
        int s = op[3:0];
        logic [31:0] a, b;
        case (c)
            1: if (mq.size() >= 8) err_m = 1; else mq.push_back(kval(s % 4));
            2: if (mq.size() >= 8) err_m = 1; else mq.push_back(pin_m[s % 4]);
            3: if (mq.size() < 1) err_m = 1; else pin_m[s % 4] = mq.pop_back();
            4: if (mq.size() < 1 || sq.size() >= 8) err_m = 1; else sq.push_back(mq.pop_back());
            5: if (sq.size() < 1 || mq.size() >= 8) err_m = 1; else mq.push_back(sq.pop_back());
            6: if (mq.size() < 1) err_m = 1; else void'(mq.pop_back());
            7: if (sq.size() < 1) err_m = 1; else void'(sq.pop_back());
            8, 9: if (s <= 8) begin
                if (mq.size() < 2 || (c == 9 && mq.size() >= 8)) err_m = 1;
                else begin
                    b = mq[mq.size()-1];
                    a = mq[mq.size()-2];
                    if (c == 8) begin void'(mq.pop_back()); void'(mq.pop_back()); end
                    mq.push_back(alu_f(s, a, b));
                end
            end
            10: if (s <= 2) begin
                if (sq.size() < 1) err_m = 1;
                else begin
                    a = sq.pop_back();
                    sq.push_back(s == 0 ? a + 1 : s == 1 ? a - 1 : ~a);
                end
            end else if (s <= 5) begin
                if (sq.size() < 2) err_m = 1;
                else begin
                    b = sq.pop_back();
                    a = sq.pop_back();
                    sq.push_back(s == 3 ? (a & b) : s == 4 ? (a | b) : (a ^ b));
                end
            end
            default: ;
        endcase
    endtask

    task automatic compare(input string tag);
        logic [31:0] em = (mq.size() > 0) ? mq[mq.size()-1] : 32'd0;
        logic [31:0] es = (sq.size() > 0) ? sq[sq.size()-1] : 32'd0;
        n_chk++;
        if (main_top !== em || main_depth !== 4'(mq.size()) || stage_top !== es ||
            stage_depth !== 4'(sq.size()) || fault !== err_m || in_ready !== 1'b1) begin
            n_fail++;
            $display("FAIL %s: actual m=%h/%0d s=%h/%0d f=%b rdy=%b expected m=%h/%0d s=%h/%0d f=%b rdy=1",
                     tag, main_top, main_depth, stage_top, stage_depth, fault, in_ready,
                     em, mq.size(), es, sq.size(), err_m);
        end
    endtask

    task automatic issue(input logic [7:0] op, input string tag);
        in_op    = op;
        in_valid = 1'b1;
        model_step(op);
        @(negedge clk);
        in_valid = 1'b0;
        compare(tag);
    endtask

    task automatic idle(input logic [7:0] op, input string tag);
        in_op    = op;
        in_valid = 1'b0;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst      = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        mq.delete();
        sq.delete();
        for (int i = 0; i < 4; i++) pin_m[i] = 32'd0;
        err_m = 0;
        compare("R1 reset");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        in_op = 8'h00;
        @(negedge clk);
        do_reset();

        // R2: every constant
        for (int k = 0; k < 4; k++) issue(8'h10 | 8'(k), "R2 push constant");
        // R10 drops, back to empty; R12 empty tops
        for (int k = 0; k < 4; k++) issue(8'h60, "R10 drop main");
        idle(8'h00, "R12 empty top");

        // R4/R6: consuming forms over all selects
        for (int s = 0; s <= 8; s++) begin
            issue(8'h12, "R6 operand a");
            issue(8'h11, "R6 operand b");
            issue(8'h80 | 8'(s), "R4 R6 consuming");
            issue(8'h60, "R10 drop result");
        end
        // shift by larger amounts, LT both ways
        issue(8'h13, "R6 setup");
        issue(8'h11, "R6 setup");
        issue(8'h80, "R6 add 0x80000001");
        issue(8'h11, "R6 setup");
        issue(8'h11, "R6 setup");
        issue(8'h80, "R6 make 2");
        issue(8'h96, "R5 R6 preserve shr");
        issue(8'h98, "R5 R6 preserve lt");
        issue(8'h60, "R10 drop");
        issue(8'h95, "R5 R6 preserve shl");
        issue(8'h97, "R5 R6 preserve eq");
        issue(8'h60, "R10 drop");
        issue(8'h60, "R10 drop");
        issue(8'h91, "R5 preserve sub");
        issue(8'h92, "R5 preserve and");

        // R7 pinned store/load
        issue(8'h32, "R7 store pin2");
        issue(8'h33, "R7 store pin3");
        issue(8'h23, "R7 load pin3");
        issue(8'h22, "R7 load pin2");
        issue(8'h20, "R7 load pin0");

        // R8 moves and R9 staging ops
        issue(8'h40, "R8 main to stage");
        issue(8'h40, "R8 main to stage");
        issue(8'h40, "R8 main to stage");
        issue(8'hA0, "R9 inc");
        issue(8'hA1, "R9 dec");
        issue(8'hA1, "R9 dec");
        issue(8'hA2, "R9 not");
        issue(8'hA3, "R9 and");
        issue(8'h40, "R8 main to stage");
        issue(8'hA4, "R9 or");
        issue(8'h40, "R8 main to stage");
        issue(8'hA5, "R9 xor");
        issue(8'h50, "R8 stage to main");
        issue(8'h70, "R10 drop stage");

        // R11: idle and undefined codes
        idle(8'h11, "R11 valid low push");
        idle(8'h60, "R11 valid low drop");
        issue(8'h00, "R11 nop class");
        issue(8'hB0, "R11 class B");
        issue(8'hF3, "R11 class F");
        issue(8'h8F, "R11 alu select 15");
        issue(8'h9C, "R11 alu select 12");
        issue(8'hA6, "R11 stage select 6");

        // R3: underflow, then overflow, state frozen
        do_reset();
        issue(8'h60, "R3 underflow drop main");
        issue(8'h11, "R3 sticky then push");
        issue(8'h80, "R3 underflow consume");
        issue(8'hA3, "R3 underflow stage binary");
        do_reset();
        for (int k = 0; k < 8; k++) issue(8'h10 | 8'(k % 4), "R3 fill");
        issue(8'h11, "R3 overflow push");
        issue(8'h90, "R3 overflow preserve");
        issue(8'h22, "R3 overflow load pin");
        for (int k = 0; k < 8; k++) issue(8'h40, "R8 fill stage");
        issue(8'h40, "R3 move into full stage");
        issue(8'h11, "R3 push after moves");
        for (int k = 0; k < 8; k++) issue(8'h70, "R10 drain stage");
        issue(8'hA0, "R3 underflow stage inc");

        // R1: reset clears pinned registers
        issue(8'h11, "R7 setup");
        issue(8'h31, "R7 store pin1");
        do_reset();
        issue(8'h21, "R1 pinned cleared");
        issue(8'h23, "R1 pinned cleared");

        finish_run();
    end

endmodule